// File: doc/BRIEF.md
# Parallel DAC Front End with Power Modes

This block is the digital side of a parallel-input 10-bit digital-to-analog converter. It latches a data word from a parallel bus and passes it through a two-stage register pipeline, so each word reaches the output code one rising edge after it was latched. An active-low chip select gates the latching. Two control pins, a DAC enable and a power-down select, choose between running, a low-power standby and a full shutdown.

Leaving either low-power mode takes a settling interval, and that interval is longer after shutdown than after standby. Both intervals are given in clock cycles. A wake-up counter holds the valid flag low until the interval has elapsed. While the converter is not running, the block reports its output as either high-impedance or tied to ground; a parameter picks which of the two variants is built. The pipeline is frozen outside the running mode, so a wake-up restores the code that was held before power-down.

Top module: `dac_front_end`

## Requirements
- R1: A synchronous active-high reset clears both pipeline registers to zero and places the block in standby: mode code 2'b00, code_out zero, out_valid low.
- R2: While running with cs_n low, the word on din at a rising edge goes into the first register, and the previous first-register word goes into the second register, which drives code_out. A word therefore appears on code_out after the second rising edge.
- R3: While cs_n is high, both pipeline registers keep their contents, whatever din carries.
- R4: With pwr_down high, the next mode is shutdown (2'b11), whatever the value of en_dac.
- R5: With pwr_down low and en_dac low, the next mode is standby (2'b00).
- R6: With pwr_down low and en_dac high in standby, the block enters the waking mode (2'b01) for exactly WAKE_STBY cycles and then becomes active (2'b10).
- R7: With pwr_down low and en_dac high in shutdown, the block enters the waking mode for exactly WAKE_SHDN cycles and then becomes active.
- R8: out_valid is high only in the active mode. In every other mode, code_out reads zero.
- R9: Outside the active mode, the current-output variant (VOLTAGE_OUT=0) raises out_hiz and the voltage-output variant (VOLTAGE_OUT=1) raises out_gnd. In the active mode both are low.
- R10: The pipeline loads only in the active mode, so din is ignored in every other mode. After a wake-up, code_out shows the code that was held before power-down.
- R11: A standby request or a shutdown request during waking abandons the wake-up, and the block goes to the requested mode on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; enables data latching |
| en_dac | input | 1 | DAC enable control |
| pwr_down | input | 1 | Power-down select; high forces shutdown |
| din | input | W | Parallel data word |
| code_out | output | W | Code from the second pipeline register, zero when not active |
| out_hiz | output | 1 | Output reported as high-impedance (current-output variant) |
| out_gnd | output | 1 | Output reported as tied to ground (voltage-output variant) |
| out_valid | output | 1 | High once the wake-up interval has elapsed |
| mode_o | output | 2 | Mode: 00 standby, 01 waking, 10 active, 11 shutdown |

## Verification
Several rules are checked by the assertions on every cycle:
- the reset state;
- the forced move into shutdown and into standby;
- that the active mode is entered only from waking, and never before the shorter wake-up interval has been spent;
- a zero code and exactly one off-state indication whenever the block is not valid;
- a stable code while chip select stays high.

Other behaviour needs the bench's scenarios to show it:
- the exact pipeline latency for several data patterns;
- the exact length of each wake-up interval;
- restoring the pre-power-down code after a wake-up, with the data bus toggling during the low-power modes;
- abandoning a wake-up part way through.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY  = 2'b00,
        PM_WAKING   = 2'b01,
        PM_ACTIVE   = 2'b10,
        PM_SHUTDOWN = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        REQ_STANDBY  = 2'b00,
        REQ_RUN      = 2'b01,
        REQ_SHUTDOWN = 2'b10
    } pwr_req_e;

    typedef struct packed {
        logic hiz;
        logic gnd;
    } off_ind_t;

    // Power-down select dominates; otherwise the enable picks run or standby.
    function automatic pwr_req_e decode_req(input logic pd, input logic en);
        if (pd)
            return REQ_SHUTDOWN;
        else if (en)
            return REQ_RUN;
        else
            return REQ_STANDBY;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacfe_mode_ctrl.sv
module dacfe_mode_ctrl
    import dacfe_pkg::*;
#(
    parameter int WAKE_STBY = 20,
    parameter int WAKE_SHDN = 2000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_down,
    input  logic      en_dac,
    output pwr_mode_e mode
);
    localparam int CW = $clog2(max_int(WAKE_STBY, WAKE_SHDN) + 1);
    localparam logic [CW-1:0] LOAD_STBY = CW'(WAKE_STBY - 1);
    localparam logic [CW-1:0] LOAD_SHDN = CW'(WAKE_SHDN - 1);

    logic [CW-1:0] wake_cnt;
    pwr_req_e      req;

    assign req = decode_req(pwr_down, en_dac);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= PM_STANDBY;
            wake_cnt <= '0;
        end else begin
            unique case (req)
                REQ_SHUTDOWN: begin
                    mode     <= PM_SHUTDOWN;
                    wake_cnt <= '0;
                end
                REQ_RUN: begin
                    unique case (mode)
                        PM_STANDBY: begin
                            mode     <= PM_WAKING;
                            wake_cnt <= LOAD_STBY;
                        end
                        PM_SHUTDOWN: begin
                            mode     <= PM_WAKING;
                            wake_cnt <= LOAD_SHDN;
                        end
                        PM_WAKING: begin
                            if (wake_cnt == '0)
                                mode <= PM_ACTIVE;
                            else
                                wake_cnt <= wake_cnt - 1'b1;
                        end
                        default: mode <= PM_ACTIVE;
                    endcase
                end
                default: begin
                    mode     <= PM_STANDBY;
                    wake_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dacfe_pipe.sv
module dacfe_pipe #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dac_code
);
    logic [W-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q     <= '0;
            dac_code <= '0;
        end else if (load) begin
            in_q     <= din;
            dac_code <= in_q;
        end
    end

endmodule

// File: rtl/dacfe_out_stage.sv
module dacfe_out_stage
    import dacfe_pkg::*;
#(
    parameter int W           = 10,
    parameter bit VOLTAGE_OUT = 1'b0
) (
    input  pwr_mode_e    mode,
    input  logic [W-1:0] dac_code,
    output logic [W-1:0] code_out,
    output logic         out_hiz,
    output logic         out_gnd,
    output logic         out_valid
);
    logic     running;
    off_ind_t ind;

    assign running   = (mode == PM_ACTIVE);
    assign out_valid = running;
    assign code_out  = running ? dac_code : '0;

    generate
        if (VOLTAGE_OUT) begin : g_volt
            assign ind = '{hiz: 1'b0, gnd: !running};
        end else begin : g_curr
            assign ind = '{hiz: !running, gnd: 1'b0};
        end
    endgenerate

    assign out_hiz = ind.hiz;
    assign out_gnd = ind.gnd;

endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
    import dacfe_pkg::*;
#(
    parameter int W           = 10,
    parameter int WAKE_STBY   = 20,
    parameter int WAKE_SHDN   = 2000,
    parameter bit VOLTAGE_OUT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         en_dac,
    input  logic         pwr_down,
    input  logic [W-1:0] din,
    output logic [W-1:0] code_out,
    output logic         out_hiz,
    output logic         out_gnd,
    output logic         out_valid,
    output logic [1:0]   mode_o
);
    pwr_mode_e    mode;
    logic [W-1:0] dac_code;
    logic         load;

    dacfe_mode_ctrl #(
        .WAKE_STBY(WAKE_STBY),
        .WAKE_SHDN(WAKE_SHDN)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .pwr_down(pwr_down),
        .en_dac  (en_dac),
        .mode    (mode)
    );

    // Registers advance only while running and selected.
    assign load = (mode == PM_ACTIVE) && !cs_n;

    dacfe_pipe #(.W(W)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .din     (din),
        .dac_code(dac_code)
    );

    dacfe_out_stage #(
        .W          (W),
        .VOLTAGE_OUT(VOLTAGE_OUT)
    ) u_out (
        .mode     (mode),
        .dac_code (dac_code),
        .code_out (code_out),
        .out_hiz  (out_hiz),
        .out_gnd  (out_gnd),
        .out_valid(out_valid)
    );

    assign mode_o = mode;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int W         = 10,
    parameter int WAKE_STBY = 20,
    parameter int WAKE_SHDN = 2000
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         en_dac,
    input logic         pwr_down,
    input logic [W-1:0] code_out,
    input logic         out_hiz,
    input logic         out_gnd,
    input logic         out_valid,
    input logic [1:0]   mode_o
);
    localparam int CW = $clog2(((WAKE_STBY > WAKE_SHDN) ? WAKE_STBY : WAKE_SHDN) + 2);

    logic [CW-1:0] wake_run;

    always_ff @(posedge clk) begin
        if (rst)
            wake_run <= '0;
        else if (mode_o == 2'b01) begin
            if (wake_run != '1)
                wake_run <= wake_run + 1'b1;
        end else
            wake_run <= '0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mode_o == 2'b00 && code_out == '0 && !out_valid));

    p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && out_valid && $past(out_valid)) |-> $stable(code_out));

    p_force_shutdown_r4: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (mode_o == 2'b11));

    p_enter_standby_r5: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && !en_dac) |=> (mode_o == 2'b00));

    p_active_via_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> ($past(mode_o) == 2'b10 || $past(mode_o) == 2'b01));

    p_wake_min_len_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && $past(mode_o) == 2'b01) |-> (int'(wake_run) >= WAKE_STBY));

    p_idle_code_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (code_out == '0));

    p_off_ind_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($countones({out_hiz, out_gnd}) == 1));

    p_on_ind_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!out_hiz && !out_gnd));

endmodule

bind dac_front_end dacfe_checker #(
    .W        (W),
    .WAKE_STBY(WAKE_STBY),
    .WAKE_SHDN(WAKE_SHDN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .en_dac   (en_dac),
    .pwr_down (pwr_down),
    .code_out (code_out),
    .out_hiz  (out_hiz),
    .out_gnd  (out_gnd),
    .out_valid(out_valid),
    .mode_o   (mode_o)
);

// File: tb/tb_dac_front_end.sv
`timescale 1ns/1ps
module tb_dac_front_end;
    localparam int W  = 10;
    localparam int WS = 4;
    localparam int WD = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         en_dac = 1'b0;
    logic         pwr_down = 1'b0;
    logic [W-1:0] din = '0;

    logic [W-1:0] code_out, code_v;
    logic         out_hiz, out_gnd, out_valid;
    logic         hiz_v, gnd_v, valid_v;
    logic [1:0]   mode_o, mode_v;

    always #10 clk = ~clk;  // 50 MHz

    dac_front_end #(.W(W), .WAKE_STBY(WS), .WAKE_SHDN(WD), .VOLTAGE_OUT(1'b0)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .en_dac(en_dac), .pwr_down(pwr_down),
        .din(din), .code_out(code_out), .out_hiz(out_hiz), .out_gnd(out_gnd),
        .out_valid(out_valid), .mode_o(mode_o));

    dac_front_end #(.W(W), .WAKE_STBY(WS), .WAKE_SHDN(WD), .VOLTAGE_OUT(1'b1)) dut_v (
        .clk(clk), .rst(rst), .cs_n(cs_n), .en_dac(en_dac), .pwr_down(pwr_down),
        .din(din), .code_out(code_v), .out_hiz(hiz_v), .out_gnd(gnd_v),
        .out_valid(valid_v), .mode_o(mode_v));

    typedef struct {
        logic [W-1:0] code;
        logic         valid;
        logic [1:0]   mode;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference model state, from the requirements
    logic [W-1:0] m_in = '0, m_dac = '0;
    logic [1:0]   m_mode = 2'b00;
    int           m_cnt = 0;

    task automatic model(input logic r, input logic c, input logic e, input logic p,
                         input logic [W-1:0] d);
        if (r) begin
            m_in = '0; m_dac = '0; m_mode = 2'b00; m_cnt = 0;
        end else begin
            if (m_mode == 2'b10 && !c) begin
                m_dac = m_in;
                m_in  = d;
            end
            if (p) m_mode = 2'b11;
            else if (!e) m_mode = 2'b00;
            else begin
                case (m_mode)
                    2'b00: begin m_mode = 2'b01; m_cnt = WS - 1; end
                    2'b11: begin m_mode = 2'b01; m_cnt = WD - 1; end
                    2'b01: if (m_cnt == 0) m_mode = 2'b10; else m_cnt = m_cnt - 1;
                    default: m_mode = 2'b10;
                endcase
            end
        end
    endtask

    task automatic step(input logic r, input logic c, input logic e, input logic p,
                        input logic [W-1:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; cs_n = c; en_dac = e; pwr_down = p; din = d;
        @(posedge clk);
        #1;
        model(r, c, e, p, d);
        it.code  = (m_mode == 2'b10) ? m_dac : '0;
        it.valid = (m_mode == 2'b10);
        it.mode  = m_mode;
        it.tag   = tag;
        q.push_back(it);
    endtask

    // Monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (code_out !== e.code || out_valid !== e.valid || mode_o !== e.mode) begin
                    n_fail++;
                    $display("FAIL %s: code=%h valid=%b mode=%b expected code=%h valid=%b mode=%b",
                             e.tag, code_out, out_valid, mode_o, e.code, e.valid, e.mode);
                end
                n_checks++;
                if (out_hiz !== !e.valid || out_gnd !== 1'b0 ||
                    hiz_v !== 1'b0 || gnd_v !== !e.valid || code_v !== e.code) begin
                    n_fail++;
                    $display("FAIL R9 (%s): hiz=%b gnd=%b vhiz=%b vgnd=%b vcode=%h expected hiz=%b gnd=0 vhiz=0 vgnd=%b vcode=%h",
                             e.tag, out_hiz, out_gnd, hiz_v, gnd_v, code_v,
                             !e.valid, !e.valid, e.code);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1, 1, 0, 0, 10'h155, "R1");
        // R5: standby request holds standby, bus ignored (R10)
        step(0, 0, 0, 0, 10'h3FF, "R5");
        step(0, 0, 0, 0, 10'h2AA, "R10");
        // R6: wake from standby, WS waking cycles
        for (int i = 0; i < WS + 1; i++) step(0, 0, 1, 0, 10'h0F0, "R6");
        // R2: streaming patterns
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, W'(i * 37 + 1), "R2");
        step(0, 0, 1, 0, 10'h3FF, "R2");
        step(0, 0, 1, 0, 10'h000, "R2");
        step(0, 0, 1, 0, 10'h2AA, "R2");
        step(0, 0, 1, 0, 10'h155, "R2");
        // R3: chip select high holds both registers
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, W'(i * 101 + 7), "R3");
        step(0, 0, 1, 0, 10'h0AB, "R3");
        step(0, 0, 1, 0, 10'h0CD, "R3");
        // R8/R10: standby with toggling bus, then wake restores the code
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, W'(i * 211 + 3), "R8");
        for (int i = 0; i < WS + 2; i++) step(0, 1, 1, 0, 10'h111, "R10");
        // R4: shutdown regardless of enable
        step(0, 0, 1, 1, 10'h222, "R4");
        step(0, 0, 0, 1, 10'h333, "R4");
        step(0, 0, 1, 1, 10'h044, "R4");
        // R7: wake from shutdown, WD waking cycles, code restored
        for (int i = 0; i < WD + 2; i++) step(0, 1, 1, 0, 10'h155, "R7");
        step(0, 0, 1, 0, 10'h301, "R7");
        step(0, 0, 1, 0, 10'h302, "R7");
        // R11: wake abandoned by standby, then by shutdown
        step(0, 0, 0, 0, 10'h000, "R11");
        step(0, 0, 1, 0, 10'h000, "R11");
        step(0, 0, 1, 0, 10'h000, "R11");
        step(0, 0, 0, 0, 10'h000, "R11");
        step(0, 0, 1, 0, 10'h000, "R11");
        step(0, 0, 1, 1, 10'h000, "R11");
        for (int i = 0; i < WD + 2; i++) step(0, 0, 1, 0, 10'h1E1, "R11");
        step(0, 0, 1, 0, 10'h1E2, "R2");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule